// File: doc/BRIEF.md
# Multichannel Converter Parallel Readout Controller

This block is the host side of a parallel link to a simultaneous-sampling, multichannel analog-to-digital converter. A one-cycle `start_i` pulse arms it for one readout. It waits until the converter's busy line is low, then holds chip-select low for the whole frame. It pulses the read strobe once per transfer. The converter moves to the next channel on every falling read edge, so results arrive in a fixed ascending order: channel index 0 first, up to `NUM_CH-1`. `NUM_CH` is meant to be 8, 6 or 4.

There are two transfer formats, sampled at `start_i`. In word mode each strobe carries a full 16-bit result. In byte mode each result takes two strobes on data lines 7:0, and `msb_first_i` sets which half arrives first. Read-low and read-high widths are given in clock cycles. A value of 0 counts as 1. The bus is sampled in the last low cycle of each strobe.

Each assembled result appears for one cycle on `res_valid_o` together with its channel index. The controller also checks the converter's first-channel flag and raises `align_err_o` on a misaligned result. `done_o` marks the final result of the readout.

The controller has four states:
- IDLE: bus released. `start_i` leads to WAIT.
- WAIT: armed. Busy low leads to LOW.
- LOW: strobe asserted. When the low timer expires the bus is captured and the state goes to HIGH.
- HIGH: strobe released. When the high timer expires the state goes back to LOW, or to IDLE after the last capture.

Top module: `adc_par_reader`

## Requirements
- R1: After `start_i`, no read strobe falls and chip-select stays high while `busy_i` is high. The first strobe falls once `busy_i` is sampled low.
- R2: `cs_n_o` is low from the first strobe to the end of the last strobe's high time. It is high in idle and while waiting. `rd_n_o` is low only while `cs_n_o` is low.
- R3: In word mode a readout has exactly `NUM_CH` strobes. Results come out in order of channel index 0, 1, … `NUM_CH-1`, and each result equals `db_i[15:0]` as sampled in that strobe.
- R4: Every strobe is low for max(`rd_low_cyc_i`,1) cycles and then high for max(`rd_high_cyc_i`,1) cycles. The bus is sampled in the last low cycle.
- R5: In byte mode a readout has exactly 2×`NUM_CH` strobes. Only `db_i[7:0]` is used, and `db_i[15:8]` has no effect on any result.
- R6: In byte mode with `msb_first_i`=1, the first byte becomes result bits 15:8 and the second byte becomes bits 7:0. With `msb_first_i`=0 the order is reversed.
- R7: `align_err_o` is raised with a result in two cases. Case 1: it is the channel-0 result and `first_data_i` was low at any of its samples. Case 2: it is the channel-1 result and `first_data_i` was still high at its first sample. Otherwise `align_err_o` is 0.
- R8: `done_o` is high for exactly one cycle per readout, in the same cycle as the result of channel `NUM_CH-1`.
- R9: A `start_i` pulse that arrives while a readout is in progress is ignored. No further strobes follow the current readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arms one readout (sampled in IDLE) |
| byte_mode_i | input | 1 | 1 = two byte transfers per result |
| msb_first_i | input | 1 | Byte order in byte mode: 1 = high byte first |
| rd_low_cyc_i | input | CNT_W | Strobe low width in cycles (0 counts as 1) |
| rd_high_cyc_i | input | CNT_W | Strobe high width in cycles (0 counts as 1) |
| busy_i | input | 1 | Converter busy indication |
| first_data_i | input | 1 | Converter first-channel flag |
| db_i | input | 16 | Converter data bus |
| cs_n_o | output | 1 | Active-low chip-select |
| rd_n_o | output | 1 | Active-low read strobe |
| res_valid_o | output | 1 | Result valid, one cycle |
| res_data_o | output | 16 | Assembled result |
| res_ch_o | output | CH_W | Channel index of the result |
| align_err_o | output | 1 | Alignment error on this result |
| done_o | output | 1 | Final result of the readout |

## Verification
A wrong channel or piece counter shows at the ports immediately. The data of the affected strobe lands under the wrong channel index, or an extra or missing strobe changes the strobe count before `done_o`. A timer or state error changes a measured low or high run within the same strobe. Swapped byte or alignment logic corrupts the very first result of a byte-mode or fault readout. The sweep covers every format, byte order and width combination, with expected words computed from the channel and round numbers.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_LOW  = 2'd2,
        S_HIGH = 2'd3
    } rd_state_e;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_assemble.sv
module adc_rd_assemble
    import adc_rd_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              byte_mode_i,
    input  logic              msb_first_i,
    input  logic              piece_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic              last_i,
    input  logic [WORD_W-1:0] db_i,
    input  logic              fd_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] data_o,
    output logic [CH_W-1:0]   ch_o,
    output logic              err_o,
    output logic              done_o
);
    logic [BYTE_W-1:0] hold_q;
    logic              err_acc_q;
    logic              piece_err;

    always_comb begin
        if (ch_i == '0) begin
            piece_err = !fd_i;
        end else if (ch_i == CH_W'(1) && !piece_i) begin
            piece_err = fd_i;
        end else begin
            piece_err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            err_acc_q <= 1'b0;
            valid_o   <= 1'b0;
            data_o    <= '0;
            ch_o      <= '0;
            err_o     <= 1'b0;
            done_o    <= 1'b0;
        end else if (cap_i && byte_mode_i && !piece_i) begin
            hold_q    <= db_i[BYTE_W-1:0];
            err_acc_q <= piece_err;
            valid_o   <= 1'b0;
            done_o    <= 1'b0;
        end else if (cap_i) begin
            valid_o <= 1'b1;
            ch_o    <= ch_i;
            done_o  <= last_i;
            if (byte_mode_i) begin
                data_o <= msb_first_i ? {hold_q, db_i[BYTE_W-1:0]}
                                      : {db_i[BYTE_W-1:0], hold_q};
                err_o  <= piece_err | err_acc_q;
            end else begin
                data_o <= db_i;
                err_o  <= piece_err;
            end
        end else begin
            valid_o <= 1'b0;
            done_o  <= 1'b0;
        end
    end

    AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (valid_o && ch_o == CH_W'(NUM_CH-1))); // R8
    AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (ch_o <= CH_W'(NUM_CH-1))); // R3
    AST_ERR_ONLY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && err_o) |-> (ch_o <= CH_W'(1))); // R7
endmodule

// File: rtl/adc_par_reader.sv
module adc_par_reader
    import adc_rd_pkg::*;
#(
    parameter int  NUM_CH = 8,
    parameter int  CNT_W  = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_mode_i,
    input  logic              msb_first_i,
    input  logic [CNT_W-1:0]  rd_low_cyc_i,
    input  logic [CNT_W-1:0]  rd_high_cyc_i,
    input  logic              busy_i,
    input  logic              first_data_i,
    input  logic [15:0]       db_i,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              res_valid_o,
    output logic [15:0]       res_data_o,
    output logic [CH_W-1:0]   res_ch_o,
    output logic              align_err_o,
    output logic              done_o
);
    rd_state_e         state_q, state_d;
    logic              cfg_byte_q, cfg_msb_q;
    logic [CNT_W-1:0]  cfg_lo_q, cfg_hi_q;
    logic [CH_W-1:0]   ch_q;
    logic              piece_q;
    logic              fin_q;
    logic              tmr_zero, tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic              cap, last_piece, load_lo;

    assign cap        = (state_q == S_LOW) && tmr_zero;
    assign last_piece = (ch_q == CH_W'(NUM_CH-1)) && (!cfg_byte_q || piece_q);
    assign load_lo    = ((state_q == S_WAIT) && !busy_i)
                     || ((state_q == S_HIGH) && tmr_zero && !fin_q);
    assign tmr_load   = load_lo || cap;
    assign tmr_len    = cap ? cfg_hi_q : cfg_lo_q;

    adc_rd_timer #(.CNT_W(CNT_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .zero_o (tmr_zero)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i)            state_d = S_WAIT;
            S_WAIT: if (!busy_i)            state_d = S_LOW;
            S_LOW:  if (tmr_zero)           state_d = S_HIGH;
            S_HIGH: if (tmr_zero)           state_d = fin_q ? S_IDLE : S_LOW;
            default:                        state_d = S_IDLE;
        endcase
    end

    // state register and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cfg_byte_q <= 1'b0;
            cfg_msb_q  <= 1'b0;
            cfg_lo_q   <= '0;
            cfg_hi_q   <= '0;
            ch_q       <= '0;
            piece_q    <= 1'b0;
            fin_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                cfg_byte_q <= byte_mode_i;
                cfg_msb_q  <= msb_first_i;
                cfg_lo_q   <= rd_low_cyc_i;
                cfg_hi_q   <= rd_high_cyc_i;
                ch_q       <= '0;
                piece_q    <= 1'b0;
                fin_q      <= 1'b0;
            end else if (cap) begin
                if (last_piece) begin
                    fin_q <= 1'b1;
                end else if (cfg_byte_q && !piece_q) begin
                    piece_q <= 1'b1;
                end else begin
                    piece_q <= 1'b0;
                    ch_q    <= ch_q + 1'b1;
                end
            end
        end
    end

    // bus control outputs
    always_comb begin
        cs_n_o = 1'b1;
        rd_n_o = 1'b1;
        unique case (state_q)
            S_IDLE, S_WAIT: begin
                cs_n_o = 1'b1;
                rd_n_o = 1'b1;
            end
            S_LOW: begin
                cs_n_o = 1'b0;
                rd_n_o = 1'b0;
            end
            S_HIGH: begin
                cs_n_o = 1'b0;
                rd_n_o = 1'b1;
            end
            default: begin
                cs_n_o = 1'b1;
                rd_n_o = 1'b1;
            end
        endcase
    end

    adc_rd_assemble #(.NUM_CH(NUM_CH), .CH_W(CH_W)) asm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (cap),
        .byte_mode_i (cfg_byte_q),
        .msb_first_i (cfg_msb_q),
        .piece_i     (piece_q),
        .ch_i        (ch_q),
        .last_i      (last_piece),
        .db_i        (db_i),
        .fd_i        (first_data_i),
        .valid_o     (res_valid_o),
        .data_o      (res_data_o),
        .ch_o        (res_ch_o),
        .err_o       (align_err_o),
        .done_o      (done_o)
    );

    AST_RD_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !cs_n_o); // R2
    AST_WAIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && busy_i) |=> rd_n_o); // R1
    AST_CAPTURE_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n_o) |-> $past(cap)); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOW && start_i) |=> (state_q != S_WAIT)); // R9
endmodule

// File: tb/adc_par_reader_tb.sv
module adc_par_reader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 8;
    localparam int CNT_W = 4;
    localparam int CH_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, byte_mode = 1'b0, msb_first = 1'b0, busy = 1'b0;
    logic [CNT_W-1:0] lo_cyc = '0, hi_cyc = '0;
    logic [15:0] db = 16'hDEAD;
    logic fd;
    logic cs_n, rd_n, valid, err, done;
    logic [15:0] rdata;
    logic [CH_W-1:0] rch;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_par_reader #(.NUM_CH(N), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_mode_i(byte_mode),
        .msb_first_i(msb_first), .rd_low_cyc_i(lo_cyc), .rd_high_cyc_i(hi_cyc),
        .busy_i(busy), .first_data_i(fd), .db_i(db), .cs_n_o(cs_n), .rd_n_o(rd_n),
        .res_valid_o(valid), .res_data_o(rdata), .res_ch_o(rch),
        .align_err_o(err), .done_o(done));

    int tests = 0, fails = 0;
    int round_id = 0, fault = 0;
    int rd_falls = 0, rises = 0, busy_viol = 0;
    int exp_idx = 0, done_cnt = 0, res_bad = 0;
    int exp_lo = 1, exp_hi = 1, lo_run = 0, hi_run = 0, width_bad = 0;
    bit summary_done = 0;

    function automatic logic [15:0] val(int r, int k);
        return 16'((r * 16'h0135) ^ (k * 16'h2301) ^ 16'h8C4A);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // converter model: first-data flag
    always_comb begin
        if (fault == 1)      fd = 1'b1;
        else if (fault == 2) fd = 1'b0;
        else                 fd = (rises < (byte_mode ? 2 : 1));
    end

    always @(negedge rd_n) begin
        int idx, ch, pc;
        logic [15:0] w;
        idx = rd_falls;
        ch  = byte_mode ? idx / 2 : idx;
        pc  = idx % 2;
        w   = val(round_id, ch);
        if (busy) busy_viol++;
        if (byte_mode)
            db <= {8'h5A, (pc == 0) == msb_first ? w[15:8] : w[7:0]};
        else
            db <= w;
        rd_falls++;
    end

    always @(posedge rd_n) begin
        rises++;
        db <= 16'hDEAD;
    end

    // output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid) begin
                logic exp_err;
                exp_err = (fault == 2 && exp_idx == 0) || (fault == 1 && exp_idx == 1);
                if (rch != CH_W'(exp_idx) || rdata != val(round_id, exp_idx)
                    || err != exp_err || done != (exp_idx == N-1)) begin
                    res_bad++;
                    $display("FAIL R3/R6/R7/R8 ch=%0d data=%h err=%0d expected ch=%0d data=%h err=%0d",
                             rch, rdata, err, exp_idx, val(round_id, exp_idx), exp_err);
                end
                exp_idx++;
            end
            if (done) done_cnt++;
            if (!rd_n) lo_run++;
            else if (lo_run > 0) begin
                if (lo_run != exp_lo) width_bad++;
                lo_run = 0;
            end
            if (!cs_n && rd_n) hi_run++;
            else if (hi_run > 0) begin
                if (hi_run != exp_hi) width_bad++;
                hi_run = 0;
            end
        end
    end

    task automatic run_round(bit b, bit m, int lo, int hi, int flt, int busy_cyc, bit extra);
        bit cs_during_busy;
        int falls_at_done;
        byte_mode = b; msb_first = m;
        lo_cyc = CNT_W'(lo); hi_cyc = CNT_W'(hi);
        exp_lo = (lo == 0) ? 1 : lo;
        exp_hi = (hi == 0) ? 1 : hi;
        fault = flt; round_id++;
        rd_falls = 0; rises = 0; busy_viol = 0; exp_idx = 0; done_cnt = 0;
        res_bad = 0; width_bad = 0;
        cs_during_busy = 0;
        @(posedge clk); busy <= 1'b1; start <= 1'b1;
        @(posedge clk); start <= 1'b0;
        for (int i = 0; i < busy_cyc; i++) begin
            @(negedge clk); if (!cs_n || !rd_n) cs_during_busy = 1;
        end
        @(posedge clk); busy <= 1'b0;
        if (extra) begin
            repeat (3) @(posedge clk);
            start <= 1'b1;
            @(posedge clk); start <= 1'b0;
        end
        for (int i = 0; i < 4000 && done_cnt == 0; i++) @(negedge clk);
        falls_at_done = rd_falls;
        repeat (40) @(negedge clk);
        chk(!cs_during_busy && busy_viol == 0, "R1 strobe while busy", busy_viol, 0);
        chk(rd_falls == (b ? 2*N : N), b ? "R5 strobe count" : "R3 strobe count", rd_falls, b ? 2*N : N);
        chk(exp_idx == N && res_bad == 0, "R3/R6 results", res_bad, 0);
        chk(width_bad == 0, "R4 strobe widths", width_bad, 0);
        chk(done_cnt == 1, "R8 done pulses", done_cnt, 1);
        chk(cs_n == 1'b1, "R2 cs released after frame", int'(cs_n), 1);
        if (flt != 0) chk(res_bad == 0, "R7 alignment flag", res_bad, 0);
        if (extra) chk(rd_falls == falls_at_done, "R9 extra start ignored", rd_falls, falls_at_done);
    endtask

    initial begin
        int los[3] = '{0, 1, 3};
        repeat (3) @(posedge clk);
        #1;
        chk(cs_n == 1'b1 && rd_n == 1'b1, "R2 reset bus idle", int'({cs_n, rd_n}), 3);
        chk(valid == 1'b0 && done == 1'b0, "R8 reset outputs", int'({valid, done}), 0);
        rst_n = 1'b1;
        for (int b = 0; b < 2; b++)
            for (int m = 0; m < 2; m++)
                for (int l = 0; l < 3; l++)
                    for (int h = 1; h < 3; h++)
                        run_round(b[0], m[0], los[l], h, 0, 2 + l, 1'b0);
        run_round(1'b0, 1'b0, 2, 1, 1, 3, 1'b0);
        run_round(1'b0, 1'b0, 2, 1, 2, 3, 1'b0);
        run_round(1'b1, 1'b1, 1, 2, 1, 1, 1'b0);
        run_round(1'b1, 1'b0, 1, 2, 2, 1, 1'b0);
        run_round(1'b0, 1'b1, 2, 2, 0, 4, 1'b1);
        run_round(1'b1, 1'b1, 2, 1, 0, 4, 1'b1);
        if (!summary_done) begin
            summary_done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!summary_done) begin
            summary_done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule